// File: doc/BRIEF.md
# Multi-Level Trace Trigger Sequencer

This block controls capture for a state-mode bus analyzer. Each sample is a 24-bit address, a 4-bit bus-cycle status and a 16-bit data word. A sample is taken when the sample-enable input rises. The block checks each sample against two programmable patterns, named arm and trigger. Every bit of a pattern can be 0, 1 or don't-care. After a start, the sequencer runs a fixed three-level program. Level 0 waits for the arm pattern. Level 1 waits for the trigger pattern. Level 2 stores a programmed number of further samples and then stops.

Every sample taken while the sequencer runs produces a one-cycle store strobe and a write address for a circular trace memory. A flag marks the stored samples that moved the level forward. The memory address of the trigger sample is latched, and a done flag reports the end of capture. Pattern and count registers are loaded through a small write port. That port is locked while a capture runs.

Top module: `trace_trig_seq`

## Requirements
- R1: A pattern is a value/mask pair. A sampled bit matches when its mask bit is 0, or when it equals the value bit. A sample matches a pattern when all 44 bits match. The status field uses these codes: 0 supervisor program read, 1 user program read, 2 user data read, 3 user data write, 4 user program write, 5 supervisor data read, 6 supervisor data write, 7 supervisor program write, 8 bus acknowledge, 9 to F interrupt acknowledge for priority levels 1 to 7.
- R2: After reset, the outputs are: level_o 0, running_o 0, done_o 0, trig_o 0, store_o 0, waddr_o 0. All mask bits are 0, so every pattern matches any sample. The post-trigger count is 508.
- R3: A pulse on start_i sets running_o. It also clears the level, the write pointer, trig_o and done_o.
- R4: In level 0, a sample that matches the arm pattern moves the level to 1. In level 1, a sample that matches the trigger pattern moves the level to 2. Each sample advances the level by at most one step, even when it matches both patterns.
- R5: While running_o is 1, every sample raises store_o for exactly one cycle. In that same cycle, waddr_o holds the write pointer. The pointer then advances and wraps from DEPTH-1 to 0. When running_o is 0, samples are not stored.
- R6: The trigger sample loads the post-trigger count N. After N more stored samples, done_o is set and running_o is cleared. If N is 0, this happens on the trigger sample itself. done_o stays set until the next start.
- R7: The trigger sample sets trig_o and latches its own write address on trig_addr_o.
- R8: lvl_chg_o is 1 together with store_o exactly for the stored sample that advanced the level.
- R9: Register writes are ignored while running_o is 1.
- R10: A sample is evaluated only in the cycle after smp_en_i rises. Holding smp_en_i high for several cycles yields a single sample.
- R11: The write port decodes cfg_addr_i as follows:
  - Bit 3 set: the post-trigger count, taken from wdata[15:0].
  - Bit 3 clear, bit 2 selects the pattern: 0 arm, 1 trigger.
  - Bit 3 clear, bit 1 selects the register: 0 value, 1 mask.
  - Bit 3 clear, bit 0 selects the field. With bit 0 clear, the address field is taken from wdata[23:0]. With bit 0 set, wdata[19:16] is the status and wdata[15:0] is the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a new capture |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register select |
| cfg_wdata_i | input | 32 | Register write data |
| smp_en_i | input | 1 | Sample-clock enable; a rising edge takes a sample |
| smp_addr_i | input | 24 | Sampled bus address |
| smp_stat_i | input | 4 | Sampled bus-cycle status code |
| smp_data_i | input | 16 | Sampled bus data |
| store_o | output | 1 | Store strobe for trace memory |
| waddr_o | output | 10 | Trace memory write address |
| lvl_chg_o | output | 1 | Stored sample caused a level change |
| level_o | output | 2 | Current trace level |
| running_o | output | 1 | Capture in progress |
| trig_o | output | 1 | Trigger seen |
| trig_addr_o | output | 10 | Write address of the trigger sample |
| done_o | output | 1 | Post-trigger count expired |

## Verification
The assertions assume that smp_en_i is a level signal, sampled on the same clock. They also assume that no sample is presented in the cycle of a start pulse. The bench therefore drives every input only on the falling clock edge. It separates samples by at least one low cycle of smp_en_i. It issues start and register writes only between samples. Register writes are made while idle, except for the single write that tests the lock.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_ARM  = 2'd0;
  localparam lvl_t LVL_WAIT = 2'd1;
  localparam lvl_t LVL_POST = 2'd2;
  localparam int   NUM_PAT  = 2;
  localparam int   PAT_ARM  = 0;
  localparam int   PAT_TRIG = 1;
endpackage

// File: rtl/tts_pat_regs.sv
module tts_pat_regs #(
  parameter int ADDR_W   = 24,
  parameter int LOW_W    = 20,
  parameter int CNT_W    = 16,
  parameter int CFG_W    = 32,
  parameter int POST_DEF = 508,
  localparam int SMP_W   = ADDR_W + LOW_W
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   lock_i,
  input  logic                                   we_i,
  input  logic [3:0]                             addr_i,
  input  logic [CFG_W-1:0]                       wdata_i,
  output logic [trace_seq_pkg::NUM_PAT-1:0][SMP_W-1:0] val_o,
  output logic [trace_seq_pkg::NUM_PAT-1:0][SMP_W-1:0] msk_o,
  output logic [CNT_W-1:0]                       post_o
);
  import trace_seq_pkg::*;

  logic wr_ok;
  assign wr_ok = we_i && !lock_i;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[CFG_W-1:ADDR_W];

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    logic sel;
    assign sel = wr_ok && !addr_i[3] && (addr_i[2] == 1'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_o[p] <= '0;
        msk_o[p] <= '0;
      end else if (sel) begin
        if (!addr_i[0]) begin
          if (addr_i[1]) msk_o[p][SMP_W-1 -: ADDR_W] <= wdata_i[ADDR_W-1:0];
          else           val_o[p][SMP_W-1 -: ADDR_W] <= wdata_i[ADDR_W-1:0];
        end else begin
          if (addr_i[1]) msk_o[p][LOW_W-1:0] <= wdata_i[LOW_W-1:0];
          else           val_o[p][LOW_W-1:0] <= wdata_i[LOW_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 post_o <= CNT_W'(POST_DEF);
    else if (wr_ok && addr_i[3]) post_o <= wdata_i[CNT_W-1:0];
  end

  assert_cfg_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(post_o) && $stable(val_o) && $stable(msk_o)));
endmodule

// File: rtl/tts_pat_match.sv
module tts_pat_match #(
  parameter int SMP_W = 44
) (
  input  logic [SMP_W-1:0] smp_i,
  input  logic [SMP_W-1:0] val_i,
  input  logic [SMP_W-1:0] msk_i,
  output logic             hit_o
);
  // only bits with mask set take part in the compare
  assign hit_o = ((smp_i ^ val_i) & msk_i) == '0;
endmodule

// File: rtl/tts_seq_ctrl.sv
module tts_seq_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      smp_rise_i,
  input  logic                      hit_arm_i,
  input  logic                      hit_trig_i,
  input  logic [CNT_W-1:0]          post_i,
  output trace_seq_pkg::lvl_t       level_o,
  output logic                      running_o,
  output logic                      done_o,
  output logic                      trig_o,
  output logic                      fire_o,
  output logic                      adv_o,
  output logic                      trig_hit_o
);
  import trace_seq_pkg::*;

  lvl_t             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire_o     = smp_rise_i && running_o && !start_i;
  assign trig_hit_o = fire_o && (lvl_q == LVL_WAIT) && hit_trig_i;
  assign adv_o      = trig_hit_o || (fire_o && (lvl_q == LVL_ARM) && hit_arm_i);
  assign level_o    = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= LVL_ARM;
      cnt_q     <= '0;
      running_o <= 1'b0;
      done_o    <= 1'b0;
      trig_o    <= 1'b0;
    end else if (start_i) begin
      lvl_q     <= LVL_ARM;
      cnt_q     <= '0;
      running_o <= 1'b1;
      done_o    <= 1'b0;
      trig_o    <= 1'b0;
    end else if (fire_o) begin
      case (lvl_q)
        LVL_ARM: if (hit_arm_i) lvl_q <= LVL_WAIT;
        LVL_WAIT: if (hit_trig_i) begin
          lvl_q  <= LVL_POST;
          trig_o <= 1'b1;
          cnt_q  <= post_i;
          if (post_i == '0) begin
            done_o    <= 1'b1;
            running_o <= 1'b0;
          end
        end
        LVL_POST: begin
          cnt_q <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            done_o    <= 1'b1;
            running_o <= 1'b0;
          end
        end
        default: lvl_q <= LVL_ARM;
      endcase
    end
  end

  assert_one_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ((lvl_q == $past(lvl_q) + 2'd1) || (lvl_q == LVL_ARM)));
  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !running_o);
endmodule

// File: rtl/tts_wptr.sv
module tts_wptr #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fire_i,
  input  logic          adv_i,
  input  logic          trig_hit_i,
  output logic          store_o,
  output logic [AW-1:0] waddr_o,
  output logic          lvl_chg_o,
  output logic [AW-1:0] trig_addr_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      waddr_o     <= '0;
      store_o     <= 1'b0;
      lvl_chg_o   <= 1'b0;
      trig_addr_o <= '0;
    end else if (start_i) begin
      ptr_q       <= '0;
      waddr_o     <= '0;
      store_o     <= 1'b0;
      lvl_chg_o   <= 1'b0;
      trig_addr_o <= '0;
    end else begin
      store_o   <= fire_i;
      lvl_chg_o <= adv_i;
      if (fire_i) begin
        waddr_o <= ptr_q;
        ptr_q   <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + AW'(1);
      end
      if (trig_hit_i) trig_addr_o <= ptr_q;
    end
  end

  assert_store_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |=> !store_o);
  assert_chg_with_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_chg_o |-> store_o);
endmodule

// File: rtl/trace_trig_seq.sv
module trace_trig_seq #(
  parameter int ADDR_W   = 24,
  parameter int STAT_W   = 4,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int CFG_W    = 32,
  parameter int DEPTH    = 1024,
  parameter int POST_DEF = 508,
  localparam int AW      = $clog2(DEPTH),
  localparam int LOW_W   = STAT_W + DATA_W,
  localparam int SMP_W   = ADDR_W + LOW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              smp_en_i,
  input  logic [ADDR_W-1:0] smp_addr_i,
  input  logic [STAT_W-1:0] smp_stat_i,
  input  logic [DATA_W-1:0] smp_data_i,
  output logic              store_o,
  output logic [AW-1:0]     waddr_o,
  output logic              lvl_chg_o,
  output logic [1:0]        level_o,
  output logic              running_o,
  output logic              trig_o,
  output logic [AW-1:0]     trig_addr_o,
  output logic              done_o
);
  import trace_seq_pkg::*;

  logic [NUM_PAT-1:0][SMP_W-1:0] val, msk;
  logic [NUM_PAT-1:0]            hit;
  logic [CNT_W-1:0]              post;
  logic [SMP_W-1:0]              smp;
  logic                          en_q, rise, fire, adv, trig_hit;

  assign smp  = {smp_addr_i, smp_stat_i, smp_data_i};
  assign rise = smp_en_i && !en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= smp_en_i;
  end

  tts_pat_regs #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .POST_DEF(POST_DEF)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(running_o),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .val_o(val), .msk_o(msk), .post_o(post)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_match
    tts_pat_match #(.SMP_W(SMP_W)) u_match (
      .smp_i(smp), .val_i(val[p]), .msk_i(msk[p]), .hit_o(hit[p])
    );
  end

  tts_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .smp_rise_i(rise),
    .hit_arm_i(hit[PAT_ARM]), .hit_trig_i(hit[PAT_TRIG]), .post_i(post),
    .level_o(level_o), .running_o(running_o), .done_o(done_o), .trig_o(trig_o),
    .fire_o(fire), .adv_o(adv), .trig_hit_o(trig_hit)
  );

  tts_wptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .fire_i(fire),
    .adv_i(adv), .trig_hit_i(trig_hit), .store_o(store_o), .waddr_o(waddr_o),
    .lvl_chg_o(lvl_chg_o), .trig_addr_o(trig_addr_o)
  );

  assert_trig_in_post_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_o) |-> (level_o == LVL_POST) && store_o && (trig_addr_o == waddr_o));
endmodule

// File: tb/trace_trig_seq_tb.sv
module trace_trig_seq_tb;
  localparam int CLK_P = 10;

  logic        clk_i = 0, rst_ni = 0, start_i = 0, cfg_we_i = 0, smp_en_i = 0;
  logic [3:0]  cfg_addr_i = 0;
  logic [31:0] cfg_wdata_i = 0;
  logic [23:0] smp_addr_i = 0;
  logic [3:0]  smp_stat_i = 0;
  logic [15:0] smp_data_i = 0;
  logic        store_o, lvl_chg_o, running_o, trig_o, done_o;
  logic [9:0]  waddr_o, trig_addr_o;
  logic [1:0]  level_o;

  int checks = 0, failures = 0;

  trace_trig_seq u_dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  // addr, stat, data, level, chg, done
  localparam logic [47:0] VEC [0:7] = '{
    {24'h000200, 4'h3, 16'hBEEF, 2'd0, 1'b0, 1'b0},
    {24'h000100, 4'h3, 16'hBEEF, 2'd1, 1'b1, 1'b0},
    {24'h000100, 4'h2, 16'hBEEF, 2'd1, 1'b0, 1'b0},
    {24'h000300, 4'h3, 16'hBEEE, 2'd1, 1'b0, 1'b0},
    {24'h000400, 4'h3, 16'hBEEF, 2'd2, 1'b1, 1'b0},
    {24'h000500, 4'h0, 16'h0000, 2'd2, 1'b0, 1'b0},
    {24'h000600, 4'h8, 16'h1234, 2'd2, 1'b0, 1'b0},
    {24'h000700, 4'hF, 16'hFFFF, 2'd2, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i); cfg_we_i = 0;
  endtask

  task automatic go();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
  endtask

  task automatic samp(input logic [23:0] a, input logic [3:0] s, input logic [15:0] d);
    @(negedge clk_i); smp_addr_i = a; smp_stat_i = s; smp_data_i = d; smp_en_i = 1;
    @(negedge clk_i); smp_en_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R2 level", level_o, 0);
    chk("R2 running", running_o, 0);
    chk("R2 done", done_o, 0);
    chk("R2 trig", trig_o, 0);
    chk("R2 store", store_o, 0);
    chk("R2 waddr", waddr_o, 0);

    // R2/R6: default masks match everything, default post count 508
    go();
    chk("R3 running after start", running_o, 1);
    samp(24'h0, 4'h0, 16'h0);
    chk("R2 all-dontcare arm", level_o, 1);
    samp(24'h0, 4'h0, 16'h0);
    chk("R2 all-dontcare trig", level_o, 2);
    for (int i = 0; i < 507; i++) samp(24'(i), 4'h1, 16'h0);
    chk("R6 default count not yet done", done_o, 0);
    samp(24'h0, 4'h1, 16'h0);
    chk("R6 default 508 done", done_o, 1);
    chk("R6 running cleared", running_o, 0);

    // R11 map: arm addr==0x100; trigger stat=3 (user data write), data=BEEF
    wr(4'h0, 32'h000100);
    wr(4'h2, 32'hFFFFFF);
    wr(4'h5, 32'h0003BEEF);
    wr(4'h7, 32'h000FFFFF);
    wr(4'h8, 32'd3);
    go();
    chk("R3 done cleared", done_o, 0);
    chk("R3 trig cleared", trig_o, 0);
    chk("R3 level cleared", level_o, 0);
    for (int i = 0; i < 8; i++) begin
      samp(VEC[i][47:24], VEC[i][23:20], VEC[i][19:4]);
      chk("R5 store", store_o, 1);
      chk("R5 waddr", waddr_o, 32'(i));
      chk("R1/R4 level", level_o, 32'(VEC[i][3:2]));
      chk("R8 lvl_chg", lvl_chg_o, 32'(VEC[i][1]));
      chk("R6 done", done_o, 32'(VEC[i][0]));
    end
    chk("R7 trig", trig_o, 1);
    chk("R7 trig_addr", trig_addr_o, 4);
    samp(24'h000100, 4'h3, 16'hBEEF);
    chk("R5 no store when stopped", store_o, 0);
    chk("R6 done held", done_o, 1);

    // R9: write while running is ignored
    go();
    wr(4'h8, 32'd0);
    samp(24'h000100, 4'h0, 16'h0);
    samp(24'h000100, 4'h3, 16'hBEEF);
    chk("R9 post count not overwritten", done_o, 0);
    for (int i = 0; i < 3; i++) samp(24'h0, 4'h0, 16'h0);
    chk("R9 old count still used", done_o, 1);

    // R6: zero count ends on trigger sample
    wr(4'h8, 32'd0);
    go();
    samp(24'h000100, 4'h0, 16'h0);
    samp(24'h000900, 4'h3, 16'hBEEF);
    chk("R6 zero count done", done_o, 1);
    chk("R6 zero count stopped", running_o, 0);
    chk("R7 trig_addr zero count", trig_addr_o, 1);

    // R10: held-high enable gives one sample
    go();
    @(negedge clk_i);
    smp_addr_i = 24'h000100; smp_stat_i = 4'h2; smp_data_i = 16'h0; smp_en_i = 1;
    repeat (4) @(negedge clk_i);
    smp_en_i = 0;
    chk("R10 level after held enable", level_o, 1);
    samp(24'h000100, 4'h3, 16'hBEEF);
    chk("R10 single store while held", waddr_o, 1);
    chk("R10 trigger reached", done_o, 1);

    // R5: pointer wrap at DEPTH
    wr(4'h0, 32'hFFFFFF);
    go();
    for (int i = 0; i < 1024; i++) samp(24'h0, 4'h0, 16'h0);
    chk("R5 last before wrap", waddr_o, 1023);
    chk("R4 no arm match stays", level_o, 0);
    samp(24'h0, 4'h0, 16'h0);
    chk("R5 wrap to zero", waddr_o, 0);
    chk("R5 store after wrap", store_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule